// File: doc/BRIEF.md
# Microwire Serial Master Controller

This block is a master for a Microwire-style synchronous serial bus, driven by software through a small 16-bit register file. A transfer sends up to 16 bits, most significant bit first, then optionally receives up to 16 bits. Asserting and releasing a device select is a separate command from the transfer, so several transfers can run under one held select.

Four device selects are supported. Each one has its own six-bit setup field, which gives the sampling edge for received bits, the launch edge for sent bits, the active select level and a rate divider of 2, 4 or 8. A global clock register enables the bit clock and sets a prescaler of 2, 4, 7 or 10. The serial clock period is the prescale value times the per-select divider, in system clocks. Software polls a busy flag and a separate receive-ready flag in the control/status register.

Top module: `uw_master`

Registers are addressed by halfword index on `reg_addr` (byte offset divided by two). Index 0 is data, 1 is control/status, 2 is the setup for selects 0 and 1, 3 is the setup for selects 2 and 3, and 4 is the global clock setup.

## Requirements
- R1: After reset the data, control/status, setup and clock registers all read 0, the serial clock is low, and every select output is high, because level 0 means active-low.
- R2: A control write with bit 13 (start) clear sets the selected index from bits 11:10. If bit 12 is set, that select is driven to its active level; if bit 12 is clear, it is released. A select that is not chosen always shows the inverse of its own level bit. At most one select is active at a time.
- R3: The write phase sends the top N bits of the data register, bit 15 first, where N is control bits 9:5. Setup bit 1 sets the launch edge: 0 launches on the rising edge and the bit is valid at the falling edge; 1 launches on the falling edge and the bit is valid at the rising edge.
- R4: The read phase follows the write phase and takes in M bits, where M is control bits 4:0. Setup bit 0 picks the sampling edge (1 means falling). The bits land right-aligned in the data register, the first received bit being the most significant. Control bit 15 (ready) is then set, and a read of the data register clears it.
- R5: Control bit 14 (busy) reads 1 from the cycle after an accepted control write until that command is complete.
- R6: The serial clock idles low and toggles only while shifting. Its period is P×D system clocks, where P is clock register bits 2:1 (codes 0 to 3 give 2, 4, 7, 10) and D is setup bits 4:3 of the active select (codes 0 to 2 give 2, 4, 8).
- R7: A bit count field above 16 acts as 16. A count of 0 skips that phase. A start with both counts 0 gives no clock edges and finishes within two cycles.
- R8: While busy is set, writes to the control and data registers are ignored: a second start does not add clock edges, and the data register keeps its value.
- R9: While clock register bit 0 (enable) is 0, the serial clock does not toggle and a pending transfer stays busy. It resumes when enable is set again.
- R10: The setup for select k is in register 2 + k/2, bits 5:0 for even k and bits 11:6 for odd k. Level, edge and rate settings take effect only for that select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Halfword register index |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears ready on data reads) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| ser_clk | output | 1 | Serial bit clock |
| ser_out | output | 1 | Serial data to the device |
| ser_in | input | 1 | Serial data from the device |
| sel_out | output | 4 | Device select lines |

## Verification
The bench models a device that captures sent bits on the edge opposite the launch edge and drives its reply one read slot at a time. If a launch or sample edge were swapped, received words and captured words would shift by one bit. It measures the time between the first two rising clock edges against the prescale and divider setting, so a wrong divider code or a wrong setup-field offset shows up as a wrong period or a wrong select level. Directed cases start a transfer while one is already running, write data while busy, hold the clock disabled, and use zero and over-range counts. A design that queued commands, lost the enable gate or did not clamp the counts would produce extra or missing clock edges.

// File: rtl/uw_pkg.sv
package uw_pkg;

   localparam logic [2:0] A_DATA = 3'd0;
   localparam logic [2:0] A_CTRL = 3'd1;
   localparam logic [2:0] A_SET0 = 3'd2;
   localparam logic [2:0] A_SET1 = 3'd3;
   localparam logic [2:0] A_CLK  = 3'd4;

   localparam int SETUP_W = 6;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CMD   = 2'd1,
      ST_SHIFT = 2'd2
   } uw_state_e;

   typedef struct packed {
      logic       spare;
      logic [1:0] rate;
      logic       level;
      logic       launch_fall;
      logic       sample_fall;
   } uw_setup_t;

   function automatic logic [3:0] pre_limit(input logic [1:0] code);
      case (code)
         2'd0:    return 4'd1;
         2'd1:    return 4'd3;
         2'd2:    return 4'd6;
         default: return 4'd9;
      endcase
   endfunction

   function automatic logic [1:0] rate_limit(input logic [1:0] code);
      case (code)
         2'd0:    return 2'd0;
         2'd1:    return 2'd1;
         default: return 2'd3;
      endcase
   endfunction

endpackage

// File: rtl/uw_clk_div.sv
module uw_clk_div
   import uw_pkg::*;
#(
   parameter int PRE_W  = 4,
   parameter int RATE_W = 2
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       enable,
   input  logic [1:0] pre_code,
   input  logic [1:0] rate_code,
   output logic       half_tick
);

   logic [PRE_W-1:0]  pre_cnt;
   logic [RATE_W-1:0] rate_cnt;
   logic [PRE_W-1:0]  pre_lim;
   logic [RATE_W-1:0] rate_lim;
   logic              pre_tick;

   assign pre_lim   = PRE_W'(pre_limit(pre_code));
   assign rate_lim  = RATE_W'(rate_limit(rate_code));
   assign pre_tick  = run && enable && (pre_cnt == pre_lim);
   assign half_tick = pre_tick && (rate_cnt == rate_lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_cnt  <= '0;
         rate_cnt <= '0;
      end else if (!run) begin
         pre_cnt  <= '0;
         rate_cnt <= '0;
      end else if (enable) begin
         if (pre_tick) begin
            pre_cnt  <= '0;
            rate_cnt <= half_tick ? '0 : rate_cnt + 1'b1;
         end else begin
            pre_cnt <= pre_cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/uw_shift_engine.sv
module uw_shift_engine
   import uw_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 5
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              cmd_i,
   input  logic [CNT_W-1:0]  wr_bits,
   input  logic [CNT_W-1:0]  rd_bits,
   input  logic [DATA_W-1:0] load_word,
   input  logic              launch_fall,
   input  logic              sample_fall,
   input  logic              half_tick,
   input  logic              ser_in,
   output logic              busy,
   output logic              run,
   output logic              ser_clk,
   output logic              ser_out,
   output logic              done,
   output logic [DATA_W-1:0] rd_word
);

   localparam int MSB = DATA_W - 1;

   uw_state_e         state;
   logic [CNT_W-1:0]  wcnt, rcnt;
   logic [DATA_W-1:0] wsh, rsh;
   logic              half;
   logic [DATA_W-1:0] rsh_next;

   assign busy     = (state != ST_IDLE);
   assign run      = (state == ST_SHIFT);
   assign rd_word  = rsh;
   assign rsh_next = {rsh[MSB-1:0], ser_in};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         wcnt    <= '0;
         rcnt    <= '0;
         wsh     <= '0;
         rsh     <= '0;
         half    <= 1'b0;
         ser_clk <= 1'b0;
         ser_out <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start_i) begin
                  if ((wr_bits | rd_bits) != '0) begin
                     state   <= ST_SHIFT;
                     wcnt    <= wr_bits;
                     rcnt    <= rd_bits;
                     wsh     <= load_word;
                     rsh     <= '0;
                     half    <= 1'b0;
                     ser_clk <= 1'b0;
                     if (launch_fall) ser_out <= load_word[MSB];
                  end else begin
                     state <= ST_CMD;
                  end
               end else if (cmd_i) begin
                  state <= ST_CMD;
               end
            end
            ST_CMD: state <= ST_IDLE;
            ST_SHIFT: begin
               if (half_tick) begin
                  if (!half) begin
                     ser_clk <= 1'b1;
                     half    <= 1'b1;
                     if (wcnt != '0 && !launch_fall) ser_out <= wsh[MSB];
                     if (wcnt == '0 && !sample_fall) rsh <= rsh_next;
                  end else begin
                     ser_clk <= 1'b0;
                     half    <= 1'b0;
                     if (wcnt != '0) begin
                        wsh  <= wsh << 1;
                        wcnt <= wcnt - 1'b1;
                        if (launch_fall && wcnt > CNT_W'(1)) ser_out <= wsh[MSB-1];
                        if (wcnt == CNT_W'(1) && rcnt == '0) state <= ST_IDLE;
                     end else begin
                        if (sample_fall) rsh <= rsh_next;
                        rcnt <= rcnt - 1'b1;
                        if (rcnt == CNT_W'(1)) begin
                           state <= ST_IDLE;
                           done  <= 1'b1;
                        end
                     end
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/uw_sel_drive.sv
module uw_sel_drive #(
   parameter int NSEL  = 4,
   parameter int IDX_W = 2
)(
   input  logic             sel_on,
   input  logic [IDX_W-1:0] sel_idx,
   input  logic [NSEL-1:0]  level,
   output logic [NSEL-1:0]  sel_out
);

   for (genvar i = 0; i < NSEL; i++) begin : g_sel
      assign sel_out[i] = (sel_on && sel_idx == IDX_W'(i)) ? level[i] : ~level[i];
   end

endmodule

// File: rtl/uw_master.sv
module uw_master
   import uw_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 3,
   parameter int NSEL   = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              ser_clk,
   output logic              ser_out,
   input  logic              ser_in,
   output logic [NSEL-1:0]   sel_out
);

   localparam int CNT_W   = $clog2(DATA_W + 1);
   localparam int IDX_W   = $clog2(NSEL);
   localparam int NREG    = NSEL / 2;
   localparam int SREG_W  = 2 * SETUP_W;
   localparam int CTRL_W  = 13;

   if (DATA_W != 16) begin : g_bad_width
      $error("uw_master: the register layout needs DATA_W of 16");
   end
   if (NSEL != 4) begin : g_bad_sel
      $error("uw_master: the index field holds exactly four selects");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("uw_master: five registers need ADDR_W of at least 3");
   end

   logic [DATA_W-1:0] data_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic [SREG_W-1:0] setup_q [NREG];
   logic [2:0]        clk_q;
   logic              ready_q;
   logic              sel_on_q;
   logic [IDX_W-1:0]  sel_idx_q;
   logic [IDX_W-1:0]  xfer_idx_q;

   logic              busy, run, done, half_tick, clk_en;
   logic [DATA_W-1:0] rd_word;
   logic              ctrl_wr, start_go, cmd_go;
   logic [IDX_W-1:0]  cfg_idx;
   uw_setup_t         fields [NSEL];
   uw_setup_t         cur;
   logic [NSEL-1:0]   lvl;
   logic [CNT_W-1:0]  wr_bits, rd_bits;

   function automatic logic [CNT_W-1:0] clamp_cnt(input logic [4:0] v);
      return (v > 5'(DATA_W)) ? CNT_W'(DATA_W) : CNT_W'(v);
   endfunction

   assign clk_en   = clk_q[0];
   assign ctrl_wr  = reg_wr && (reg_addr == ADDR_W'(A_CTRL)) && !busy;
   assign start_go = ctrl_wr && reg_wdata[13];
   assign cmd_go   = ctrl_wr && !reg_wdata[13];
   assign wr_bits  = clamp_cnt(reg_wdata[9:5]);
   assign rd_bits  = clamp_cnt(reg_wdata[4:0]);
   assign cfg_idx  = start_go ? reg_wdata[11:10] : xfer_idx_q;

   for (genvar i = 0; i < NSEL; i++) begin : g_field
      assign fields[i] = uw_setup_t'(setup_q[i / 2][(i % 2) * SETUP_W +: SETUP_W]);
      assign lvl[i]    = fields[i].level;
   end

   assign cur = fields[cfg_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q     <= '0;
         ctrl_q     <= '0;
         clk_q      <= '0;
         ready_q    <= 1'b0;
         sel_on_q   <= 1'b0;
         sel_idx_q  <= '0;
         xfer_idx_q <= '0;
         for (int r = 0; r < NREG; r++) setup_q[r] <= '0;
      end else begin
         if (reg_wr) begin
            case (reg_addr)
               ADDR_W'(A_DATA): if (!busy) data_q <= reg_wdata;
               ADDR_W'(A_SET0): setup_q[0] <= reg_wdata[SREG_W-1:0];
               ADDR_W'(A_SET1): setup_q[1] <= reg_wdata[SREG_W-1:0];
               ADDR_W'(A_CLK):  clk_q <= reg_wdata[2:0];
               default: ;
            endcase
         end
         if (ctrl_wr) ctrl_q <= reg_wdata[CTRL_W-1:0];
         if (start_go) xfer_idx_q <= reg_wdata[11:10];
         if (cmd_go) begin
            sel_idx_q <= reg_wdata[11:10];
            sel_on_q  <= reg_wdata[12];
         end
         if (done) begin
            data_q  <= rd_word;
            ready_q <= 1'b1;
         end else if (start_go || (reg_rd && reg_addr == ADDR_W'(A_DATA))) begin
            ready_q <= 1'b0;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(A_DATA): reg_rdata = data_q;
         ADDR_W'(A_CTRL): reg_rdata = {ready_q, busy, 1'b0, ctrl_q};
         ADDR_W'(A_SET0): reg_rdata = DATA_W'(setup_q[0]);
         ADDR_W'(A_SET1): reg_rdata = DATA_W'(setup_q[1]);
         ADDR_W'(A_CLK):  reg_rdata = DATA_W'(clk_q);
         default:         reg_rdata = '0;
      endcase
   end

   uw_clk_div i_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .enable    (clk_en),
      .pre_code  (clk_q[2:1]),
      .rate_code (cur.rate),
      .half_tick (half_tick)
   );

   uw_shift_engine #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_eng (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start_go),
      .cmd_i       (cmd_go),
      .wr_bits     (wr_bits),
      .rd_bits     (rd_bits),
      .load_word   (data_q),
      .launch_fall (cur.launch_fall),
      .sample_fall (cur.sample_fall),
      .half_tick   (half_tick),
      .ser_in      (ser_in),
      .busy        (busy),
      .run         (run),
      .ser_clk     (ser_clk),
      .ser_out     (ser_out),
      .done        (done),
      .rd_word     (rd_word)
   );

   uw_sel_drive #(.NSEL(NSEL), .IDX_W(IDX_W)) i_sel (
      .sel_on  (sel_on_q),
      .sel_idx (sel_idx_q),
      .level   (lvl),
      .sel_out (sel_out)
   );

endmodule

// File: rtl/uw_master_chk.sv
module uw_master_chk #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 3,
   parameter int NSEL   = 4
)(
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              ser_clk,
   input logic [NSEL-1:0]   sel_out,
   input logic [NSEL-1:0]   lvl,
   input logic              busy,
   input logic              ready_q,
   input logic              done,
   input logic              clk_en,
   input logic [DATA_W-1:0] data_q
);

   logic [NSEL-1:0] active;
   for (genvar i = 0; i < NSEL; i++) begin : g_act
      assign active[i] = (sel_out[i] == lvl[i]);
   end

   // R2
   sel_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(active) <= 1);

   // R6
   clk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ser_clk |-> busy);

   // R9
   clk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en |=> $stable(ser_clk));

   // R5
   busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(reg_wr && reg_addr == ADDR_W'(1)));

   // R8
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(data_q));

   // R4
   ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == ADDR_W'(0) && !done) |=> !ready_q);

endmodule

bind uw_master uw_master_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NSEL(NSEL)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr   (reg_wr),
   .reg_rd   (reg_rd),
   .reg_addr (reg_addr),
   .ser_clk  (ser_clk),
   .sel_out  (sel_out),
   .lvl      (lvl),
   .busy     (busy),
   .ready_q  (ready_q),
   .done     (done),
   .clk_en   (clk_en),
   .data_q   (data_q)
);

// File: tb/test_uw_master.sv
`timescale 1ns/1ps
module test_uw_master;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        ser_clk, ser_out, ser_in;
   logic [3:0]  sel_out;

   int vectors = 0;
   int errors  = 0;

   // device model state
   int          nr = 0, nf = 0, wn_e = 0, rn_e = 0;
   logic        lf_e = 1'b0;
   logic [15:0] cap = '0, rdval = '0;
   longint      t1 = 0, t2 = 0;

   always #10 clk = ~clk;

   uw_master i_uw_master (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ser_clk(ser_clk), .ser_out(ser_out), .ser_in(ser_in), .sel_out(sel_out)
   );

   function automatic logic slave_bit(int f, int w, int r, logic [15:0] v);
      if (f >= w && f < w + r) return v[r - 1 - (f - w)];
      return 1'b0;
   endfunction

   assign ser_in = slave_bit(nf, wn_e, rn_e, rdval);

   always @(posedge ser_clk) begin
      if (lf_e && nr < wn_e) cap = {cap[14:0], ser_out};
      if (nr == 0) t1 = $time;
      if (nr == 1) t2 = $time;
      nr = nr + 1;
   end

   always @(negedge ser_clk) begin
      if (!lf_e && nf < wn_e) cap = {cap[14:0], ser_out};
      nf = nf + 1;
   end

   function automatic int pre_of(logic [1:0] c);
      case (c) 2'd0: return 2; 2'd1: return 4; 2'd2: return 7; default: return 10; endcase
   endfunction

   function automatic int div_of(logic [1:0] c);
      case (c) 2'd0: return 2; 2'd1: return 4; default: return 8; endcase
   endfunction

   function automatic int clamp16(int v);
      return (v > 16) ? 16 : v;
   endfunction

   function automatic logic [3:0] sel_expect(logic on, int idx, logic [3:0] lv);
      logic [3:0] r;
      for (int i = 0; i < 4; i++) r[i] = (on && i == idx) ? lv[i] : ~lv[i];
      return r;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [2:0] a, logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic peek(logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic rd_data(output logic [15:0] d);
      @(negedge clk);
      reg_addr = 3'd0; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wait_idle();
      logic [15:0] s;
      s = 16'h4000;
      while (s[14]) peek(3'd1, s);
   endtask

   task automatic arm(int w, int r, logic lf, logic [15:0] rv);
      nr = 0; nf = 0; cap = '0; t1 = 0; t2 = 0;
      wn_e = w; rn_e = r; lf_e = lf; rdval = rv;
   endtask

   function automatic logic [15:0] ctl(int rb, int wb, int idx, logic cs, logic go);
      return 16'(rb & 31) | (16'(wb & 31) << 5) | (16'(idx & 3) << 10) |
             (16'(cs) << 12) | (16'(go) << 13);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      logic [15:0] v;
      logic [5:0]  f [4];
      logic [3:0]  lv;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 5; a++) begin
         peek(3'(a), v);
         chk("R1 reg", {16'(a), v}, {16'(a), 16'h0});
      end
      chk("R1 sel", 32'(sel_out), 32'hF);
      chk("R1 sclk", 32'(ser_clk), 32'h0);

      // random transfers (R2 R3 R4 R5 R6 R7 R10)
      for (int it = 0; it < 24; it++) begin
         int idx, wraw, rraw, w, r, pc, per;
         logic [15:0] dat, rv, mask;
         idx  = $urandom_range(0, 3);
         pc   = $urandom_range(0, 3);
         for (int k = 0; k < 4; k++) begin
            f[k] = 6'($urandom_range(0, 63));
            f[k][4:3] = 2'($urandom_range(0, 2));
            lv[k] = f[k][2];
         end
         wraw = $urandom_range(0, 20);
         rraw = $urandom_range(0, 20);
         if (wraw == 0 && rraw == 0) wraw = 3;
         w = clamp16(wraw); r = clamp16(rraw);
         dat = 16'($urandom);
         rv  = 16'($urandom);
         mask = (r == 16) ? 16'hFFFF : 16'((1 << r) - 1);
         wr(3'd4, 16'(1 | (pc << 1)));
         wr(3'd2, {4'h0, f[1], f[0]});
         wr(3'd3, {4'h0, f[3], f[2]});
         wr(3'd0, dat);
         wr(3'd1, ctl(0, 0, idx, 1'b1, 1'b0));
         @(negedge clk);
         chk("R2 R10 select on", 32'(sel_out), 32'(sel_expect(1'b1, idx, lv)));
         arm(w, r, f[idx][1], rv);
         wr(3'd1, ctl(rraw, wraw, idx, 1'b1, 1'b1));
         peek(3'd1, v);
         chk("R5 busy", 32'(v[14]), 32'h1);
         wait_idle();
         repeat (2) @(negedge clk);
         chk("R7 edge count", 32'(nr), 32'(w + r));
         if (w > 0) chk("R3 sent bits", 32'(cap & 16'((1 << w) - 1)), 32'(dat >> (16 - w)));
         if (w + r >= 2) begin
            per = pre_of(2'(pc)) * div_of(f[idx][4:3]) * 20;
            chk("R6 R10 period", 32'(t2 - t1), 32'(per));
         end
         if (r > 0) begin
            peek(3'd1, v);
            chk("R4 ready set", 32'(v[15]), 32'h1);
            rd_data(v);
            chk("R4 read word", 32'(v), 32'(rv & mask));
            peek(3'd1, v);
            chk("R4 ready clear", 32'(v[15]), 32'h0);
         end else begin
            rd_data(v);
            chk("R3 data kept", 32'(v), 32'(dat));
         end
         wr(3'd1, ctl(0, 0, idx, 1'b0, 1'b0));
         @(negedge clk);
         chk("R2 select off", 32'(sel_out), 32'(sel_expect(1'b0, idx, lv)));
      end

      // R8 start and data writes while busy are ignored
      wr(3'd4, 16'h0001);
      wr(3'd2, 16'h0000);
      wr(3'd0, 16'hA5C3);
      arm(8, 0, 1'b0, 16'h0);
      wr(3'd1, ctl(0, 8, 0, 1'b0, 1'b1));
      wr(3'd1, ctl(16, 16, 0, 1'b0, 1'b1));
      wr(3'd0, 16'hFFFF);
      wait_idle();
      repeat (4) @(negedge clk);
      chk("R8 no extra edges", 32'(nr), 32'd8);
      chk("R8 sent bits", 32'(cap & 16'hFF), 32'hA5);
      rd_data(v);
      chk("R8 data unchanged", 32'(v), 32'hA5C3);

      // R9 clock enable gating
      wr(3'd4, 16'h0000);
      arm(4, 0, 1'b0, 16'h0);
      wr(3'd1, ctl(0, 4, 0, 1'b0, 1'b1));
      repeat (100) @(negedge clk);
      peek(3'd1, v);
      chk("R9 stalled busy", 32'(v[14]), 32'h1);
      chk("R9 no edges", 32'(nr), 32'h0);
      wr(3'd4, 16'h0001);
      wait_idle();
      repeat (2) @(negedge clk);
      chk("R9 resumed", 32'(nr), 32'd4);

      // R7 both counts zero
      arm(0, 0, 1'b0, 16'h0);
      wr(3'd1, ctl(0, 0, 0, 1'b0, 1'b1));
      @(negedge clk);
      peek(3'd1, v);
      chk("R7 zero finishes", 32'(v[14]), 32'h0);
      chk("R7 zero no edges", 32'(nr), 32'h0);

      // R7 read-only transfer with over-range count
      arm(0, 16, 1'b0, 16'h3C5A);
      wr(3'd1, ctl(31, 0, 0, 1'b0, 1'b1));
      wait_idle();
      repeat (2) @(negedge clk);
      rd_data(v);
      chk("R7 clamp read", 32'(v), 32'h3C5A);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule